// File: doc/BRIEF.md
# Cross Trigger Channel Router

The router connects a set of trigger inputs to a set of trigger outputs through a small number of shared broadcast channels. Each trigger input carries a mask of the channels it drives. A channel is active in a cycle when any trigger input that maps to it is high. Each trigger output carries a mask of the channels that set it. When any of those channels is active, the output goes high in the next cycle. It then stays latched until software acknowledges it.

Software programs the block through a simple register port. Writes are one-cycle requests and reads are combinational on the addressed register. The control register and all mask registers are guarded by a lock. The lock opens only when the key 0x0ACCE550 is written to it, and any other value written there closes it again. A global enable gates all routing. Software can poll the output status register to see when an acknowledged trigger has dropped.

Top module: `xtrig_router`

## Requirements
- R1: After reset the block is locked and disabled, all masks read 0, the lock register reads 0 and every trigger output is low.
- R2: While locked, writes to the control register (0x00) and to the mask registers leave their read-back values unchanged.
- R3: Writing 0x0ACCE550 to the lock register (0x04) unlocks it, and the lock register then reads 1 in bit 0. Writing any other value re-locks it, and it then reads 0.
- R4: Bit 0 of the control register is the global enable. In any cycle that starts with the enable clear, every trigger output is low after the next clock edge, whatever the inputs are.
- R5: Channel c is active when some trigger input i is high and bit c of input mask i is set. Mask bit n selects channel n, so 0x4 is channel 2 and 0x8 is channel 3.
- R6: Trigger output k goes high on the clock edge that follows a cycle in which any channel selected by output mask k is active.
- R7: A high trigger output stays high after its channels go idle. A write of 1 to bit k of the acknowledge register (0x08) clears output k on that edge, but only if none of its channels is active in that cycle. Otherwise the output stays high.
- R8: The status register (0x0C) reads the current level of every trigger output in bit k for output k. Writes to the acknowledge register take effect even while the block is locked.
- R9: Input mask i sits at address 0x20+4*i and output mask k at 0xA0+4*k. Each holds its channel mask in bits 3:0 and reads back what was last written while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register, combinational |
| trig_i | input | 8 | Trigger inputs |
| trig_o | output | 8 | Latched trigger outputs |

## Verification
The hardest case to reach is an acknowledge that arrives in the same cycle in which a mapped channel is still active. That ack must be ignored, and a later ack must then clear the output. Getting there requires the block to be unlocked, both mask stages programmed, and the bench to hold a trigger input high exactly across the ack write. The directed phase builds that sequence on channels 2 and 3. A long random phase then mixes sparse triggers, random masks, lock and relock writes, enable toggles and acks against a bench model, so that ack and activity overlap in many cycles.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int unsigned ADDR_CTRL   = 32'h00;
  localparam int unsigned ADDR_LOCK   = 32'h04;
  localparam int unsigned ADDR_ACK    = 32'h08;
  localparam int unsigned ADDR_STAT   = 32'h0C;
  localparam int unsigned ADDR_IN_B   = 32'h20;
  localparam int unsigned ADDR_OUT_B  = 32'hA0;
  localparam logic [31:0] UNLOCK_KEY  = 32'h0ACC_E550;
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [AW-1:0]               addr_i,
  input  logic [DW-1:0]               wdata_i,
  input  logic [N_OUT-1:0]            lvl_i,
  output logic [DW-1:0]               rdata_o,
  output logic                        en_o,
  output logic [N_IN-1:0][N_CH-1:0]   in_mask_o,
  output logic [N_OUT-1:0][N_CH-1:0]  out_mask_o,
  output logic [N_OUT-1:0]            ack_o
);
  localparam int IN_END  = int'(ADDR_IN_B) + 4 * N_IN;
  localparam int OUT_END = int'(ADDR_OUT_B) + 4 * N_OUT;

  logic unlocked_q, en_q;
  logic wr, cfg_wr;
  logic in_hit, out_hit;
  logic [AW-1:0] in_off, out_off;
  logic [N_IN-1:0][N_CH-1:0]  in_q;
  logic [N_OUT-1:0][N_CH-1:0] out_q;

  assign wr      = req_i && we_i;
  assign cfg_wr  = wr && unlocked_q;
  assign in_off  = addr_i - AW'(ADDR_IN_B);
  assign out_off = addr_i - AW'(ADDR_OUT_B);
  assign in_hit  = (int'(addr_i) >= int'(ADDR_IN_B)) && (int'(addr_i) < IN_END)
                   && (addr_i[1:0] == 2'b00);
  assign out_hit = (int'(addr_i) >= int'(ADDR_OUT_B)) && (int'(addr_i) < OUT_END)
                   && (addr_i[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      en_q       <= 1'b0;
    end else begin
      if (wr && addr_i == AW'(ADDR_LOCK)) unlocked_q <= (wdata_i == UNLOCK_KEY);
      if (cfg_wr && addr_i == AW'(ADDR_CTRL)) en_q <= wdata_i[0];
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) in_q[i] <= '0;
      else if (cfg_wr && in_hit && int'(in_off[AW-1:2]) == i) in_q[i] <= wdata_i[N_CH-1:0];
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q[k] <= '0;
      else if (cfg_wr && out_hit && int'(out_off[AW-1:2]) == k) out_q[k] <= wdata_i[N_CH-1:0];
    end
  end

  // ack is not configuration: accepted while locked
  assign ack_o = (wr && addr_i == AW'(ADDR_ACK)) ? wdata_i[N_OUT-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_CTRL))      rdata_o[0] = en_q;
    else if (addr_i == AW'(ADDR_LOCK)) rdata_o[0] = unlocked_q;
    else if (addr_i == AW'(ADDR_STAT)) rdata_o[N_OUT-1:0] = lvl_i;
    else if (in_hit) begin
      for (int i = 0; i < N_IN; i++)
        if (int'(in_off[AW-1:2]) == i) rdata_o[N_CH-1:0] = in_q[i];
    end else if (out_hit) begin
      for (int k = 0; k < N_OUT; k++)
        if (int'(out_off[AW-1:2]) == k) rdata_o[N_CH-1:0] = out_q[k];
    end
  end

  assign en_o       = en_q;
  assign in_mask_o  = in_q;
  assign out_mask_o = out_q;

  AST_LOCKED_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_q && wr && addr_i == AW'(ADDR_CTRL)) |=> $stable(en_q)); // R2
  AST_LOCKED_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_q && wr && (in_hit || out_hit)) |=> ($stable(in_q) && $stable(out_q))); // R2
  AST_BAD_KEY_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == AW'(ADDR_LOCK) && wdata_i != UNLOCK_KEY) |=> !unlocked_q); // R3
endmodule

// File: rtl/xtrig_matrix.sv
module xtrig_matrix #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4
) (
  input  logic [N_IN-1:0]             trig_i,
  input  logic                        en_i,
  input  logic [N_IN-1:0][N_CH-1:0]   in_mask_i,
  input  logic [N_OUT-1:0][N_CH-1:0]  out_mask_i,
  output logic [N_CH-1:0]             chan_o,
  output logic [N_OUT-1:0]            hit_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [N_IN-1:0] src;
    for (genvar i = 0; i < N_IN; i++) begin : g_src
      assign src[i] = trig_i[i] & in_mask_i[i][c];
    end
    assign chan_o[c] = en_i & (|src);
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_hit
    assign hit_o[k] = |(chan_o & out_mask_i[k]);
  end
endmodule

// File: rtl/xtrig_latch.sv
module xtrig_latch #(
  parameter int N_OUT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [N_OUT-1:0] hit_i,
  input  logic [N_OUT-1:0] ack_i,
  output logic [N_OUT-1:0] out_o
);
  logic [N_OUT-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (!en_i) q <= '0;
    else            q <= (q & ~ack_i) | hit_i;
  end

  assign out_o = q;

  AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (q == '0)); // R4
  AST_HIT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((q & $past(hit_i)) == $past(hit_i))); // R6
  AST_HOLD_UNACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((q & $past(q & ~ack_i)) == $past(q & ~ack_i))); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ack_i != '0) |=> ((q & $past(ack_i & ~hit_i)) == '0)); // R7
endmodule

// File: rtl/xtrig_router.sv
module xtrig_router #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int N_CH  = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_IN-1:0]  trig_i,
  output logic [N_OUT-1:0] trig_o
);
  logic                       en;
  logic [N_IN-1:0][N_CH-1:0]  in_mask;
  logic [N_OUT-1:0][N_CH-1:0] out_mask;
  logic [N_OUT-1:0]           ack, hit;
  logic [N_CH-1:0]            chan;

  xtrig_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH), .AW(AW), .DW(DW)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .lvl_i(trig_o), .rdata_o, .en_o(en),
    .in_mask_o(in_mask), .out_mask_o(out_mask), .ack_o(ack)
  );

  xtrig_matrix #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CH(N_CH)) i_matrix (
    .trig_i, .en_i(en), .in_mask_i(in_mask), .out_mask_i(out_mask),
    .chan_o(chan), .hit_o(hit)
  );

  xtrig_latch #(.N_OUT(N_OUT)) i_latch (
    .clk_i, .rst_ni, .en_i(en), .hit_i(hit), .ack_i(ack), .out_o(trig_o)
  );

  AST_NO_CHAN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (chan == '0)); // R4
endmodule

// File: tb/test_xtrig_router.sv
module test_xtrig_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] trig = 0, trig_o;
  int checks = 0, failures = 0;

  logic       m_unl, m_en;
  logic [3:0] m_in [8];
  logic [3:0] m_om [8];
  logic [7:0] m_out;

  always #2.5 clk = ~clk;

  xtrig_router i_xtrig_router (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .trig_i(trig), .trig_o(trig_o)
  );

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == 8'h00) return {31'b0, m_en};
    if (a == 8'h04) return {31'b0, m_unl};
    if (a == 8'h0C) return {24'b0, m_out};
    if (a >= 8'h20 && a < 8'h40 && a[1:0] == 0) return {28'b0, m_in[(a - 8'h20) >> 2]};
    if (a >= 8'hA0 && a < 8'hC0 && a[1:0] == 0) return {28'b0, m_om[(a - 8'hA0) >> 2]};
    return 32'b0;
  endfunction

  task automatic m_edge();
    logic [3:0] ch;
    logic [7:0] hit, ack, nout;
    ch = 0;
    for (int i = 0; i < 8; i++) if (trig[i]) ch |= m_in[i];
    if (!m_en) ch = 0;
    hit = 0;
    for (int k = 0; k < 8; k++) hit[k] = |(ch & m_om[k]);
    ack = (req && we && addr == 8'h08) ? wdata[7:0] : 8'h00;
    nout = m_en ? ((m_out & ~ack) | hit) : 8'h00;
    if (req && we) begin
      if (addr == 8'h04) m_unl = (wdata == 32'h0ACCE550);
      else if (m_unl) begin
        if (addr == 8'h00) m_en = wdata[0];
        else if (addr >= 8'h20 && addr < 8'h40 && addr[1:0] == 0) m_in[(addr - 8'h20) >> 2] = wdata[3:0];
        else if (addr >= 8'hA0 && addr < 8'hC0 && addr[1:0] == 0) m_om[(addr - 8'hA0) >> 2] = wdata[3:0];
      end
    end
    m_out = nout;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic r, logic w, logic [7:0] a, logic [31:0] d, logic [7:0] t);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; trig = t;
    #1;
    if (r && !w) chk(tag, rdata, m_read(a));
    @(posedge clk);
    m_edge();
    #1;
    chk(tag, {24'b0, trig_o}, {24'b0, m_out});
  endtask

  task automatic wr(string tag, logic [7:0] a, logic [31:0] d, logic [7:0] t);
    cyc(tag, 1, 1, a, d, t);
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [7:0] t);
    cyc(tag, 1, 0, a, 0, t);
  endtask

  task automatic idle(string tag, logic [7:0] t);
    cyc(tag, 0, 0, 0, 0, t);
  endtask

  initial begin
    #(5ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_unl = 0; m_en = 0; m_out = 0;
    for (int i = 0; i < 8; i++) begin m_in[i] = 0; m_om[i] = 0; end
    #12 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    chk("R1", {24'b0, trig_o}, 32'h0);
    rd("R1", 8'h00, 0); chk("R1", rdata, 32'h0);
    rd("R1", 8'h04, 0); chk("R1", rdata, 32'h0);
    rd("R1", 8'h24, 0); chk("R1", rdata, 32'h0);
    rd("R1", 8'hB8, 0); chk("R1", rdata, 32'h0);

    // R2 locked writes ignored
    wr("R2", 8'h00, 1, 0);
    rd("R2", 8'h00, 0); chk("R2", rdata, 32'h0);
    wr("R2", 8'h20, 32'hF, 0);
    rd("R2", 8'h20, 0); chk("R2", rdata, 32'h0);

    // R3 lock key
    wr("R3", 8'h04, 32'h0ACCE551, 0);
    rd("R3", 8'h04, 0); chk("R3", rdata, 32'h0);
    wr("R3", 8'h04, 32'h0ACCE550, 0);
    rd("R3", 8'h04, 0); chk("R3", rdata, 32'h1);

    // R9 mapping: input 1 -> ch2 -> output 2, input 7 -> ch3 -> output 6
    wr("R9", 8'h24, 32'h4, 0);
    wr("R9", 8'hA8, 32'h4, 0);
    wr("R9", 8'h3C, 32'h8, 0);
    wr("R9", 8'hB8, 32'h8, 0);
    rd("R9", 8'h24, 0); chk("R9", rdata, 32'h4);
    rd("R9", 8'hB8, 0); chk("R9", rdata, 32'h8);
    wr("R4", 8'h00, 1, 0);

    // R5 R6 routing
    idle("R5", 8'h02); chk("R5", {24'b0, trig_o}, 32'h04);
    idle("R6", 8'h80); chk("R6", {24'b0, trig_o}, 32'h44);
    // R7 latched after input drops
    idle("R7", 8'h00); chk("R7", {24'b0, trig_o}, 32'h44);
    // R7 ack while channel active is ignored
    wr("R7", 8'h08, 32'h04, 8'h02); chk("R7", {24'b0, trig_o}, 32'h44);
    wr("R7", 8'h08, 32'h04, 8'h00); chk("R7", {24'b0, trig_o}, 32'h40);
    // R8 status and ack while locked
    rd("R8", 8'h0C, 0); chk("R8", rdata, 32'h40);
    wr("R3", 8'h04, 32'h0, 0);
    rd("R3", 8'h04, 0); chk("R3", rdata, 32'h0);
    wr("R8", 8'h08, 32'h40, 0); chk("R8", {24'b0, trig_o}, 32'h00);
    rd("R8", 8'h0C, 0); chk("R8", rdata, 32'h0);

    // R4 disable clears and blocks
    idle("R4", 8'h02); chk("R4", {24'b0, trig_o}, 32'h04);
    wr("R3", 8'h04, 32'h0ACCE550, 0);
    wr("R4", 8'h00, 0, 8'h02); chk("R4", {24'b0, trig_o}, 32'h04);
    idle("R4", 8'h82); chk("R4", {24'b0, trig_o}, 32'h00);
    idle("R4", 8'hFF); chk("R4", {24'b0, trig_o}, 32'h00);

    // random mix, model compare on trig_o (R6) and register reads (R9)
    for (int n = 0; n < 4000; n++) begin
      automatic int op = $urandom_range(0, 15);
      automatic logic [7:0] t = 0;
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 9) == 0) t[b] = 1'b1;
      case (op)
        0: wr("R3", 8'h04, ($urandom_range(0, 3) != 0) ? 32'h0ACCE550 : $urandom(), t);
        1: wr("R4", 8'h00, ($urandom_range(0, 4) != 0) ? 32'h1 : 32'h0, t);
        2: wr("R9", 8'h20 + 8'($urandom_range(0, 7) * 4), $urandom(), t);
        3: wr("R9", 8'hA0 + 8'($urandom_range(0, 7) * 4), $urandom(), t);
        4, 5: wr("R7", 8'h08, $urandom(), t);
        6: rd("R8", 8'h0C, t);
        7: rd("R9", ($urandom_range(0, 1) != 0) ? 8'h20 + 8'($urandom_range(0, 7) * 4)
                                               : 8'hA0 + 8'($urandom_range(0, 7) * 4), t);
        default: idle("R6", t);
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule